// File: doc/BRIEF.md
# CAN Node Error Counter and Fault-Confinement Monitor

This block holds the transmit and receive error counters of a CAN node and turns them into the node's confinement state and a set of status flags. The protocol engine tells it, one cycle at a time, when an error or a success has been seen in each direction. It also reports, for each receive buffer, when a message that passed filtering arrived while that buffer was still occupied. The block answers with warning, passive and bus-off flags, a per-buffer overflow flag that firmware clears, a state code, and a one-cycle error-interrupt pulse. The pulse fires when any status flag changes or when an overflow event arrives.

An error event adds a given amount, from 1 to 15, to its counter. A success event takes one away. The transmit counter is one bit wider than the receive counter, so a count above 255 can be held. Once the node is bus-off, both counters freeze. Only a recovery request clears them again, and that request has no effect at any other time. The reset is asynchronous and active low. Its release is synchronised internally over two clock edges.

Top module: `can_errmon`

## Requirements
- R1: After reset both counters read 0, every flag reads 0, `err_state` reads 0 (active) and `err_irq` is low.
- R2: A `tec_inc` event adds `tec_inc_amt` to the transmit counter. A `tec_dec` event subtracts 1 and stops at 0. When both arrive in the same cycle, the increment wins. The result is visible in the cycle after the sampling edge.
- R3: The receive counter follows the same rules through `rec_inc`, `rec_inc_amt` and `rec_dec`, and it saturates at 255 instead of wrapping.
- R4: `tx_warn` is 1 while the transmit count is 96 or more. `rx_warn` is 1 while the receive count is 96 or more.
- R5: `tx_passive` is 1 while the transmit count exceeds 127, and `rx_passive` is 1 while the receive count exceeds 127. While either is set and the node is not bus-off, `err_state` reads 1 (passive). At a count of exactly 127 the flag stays 0.
- R6: `bus_off` is 1 while the transmit count exceeds 255, and `err_state` then reads 2, which takes precedence over passive.
- R7: While `bus_off` is 1, increment and decrement events on both counters are ignored.
- R8: `recover` sampled while bus-off clears both counters, so the node returns to state 0. `recover` sampled when the node is not bus-off has no effect.
- R9: A pulse on bit i of `ovf_evt` sets `rx_ovfl[i]`. The flag then holds until bit i of `ovf_clr` is pulsed. If set and clear arrive together, set wins.
- R10: `err_irq` is high for the single cycle after any sampling edge at which one of the five status flags changed value or any `ovf_evt` bit was 1. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tec_inc | input | 1 | Transmit error event |
| tec_inc_amt | input | 4 | Amount added by a transmit error event |
| tec_dec | input | 1 | Transmit success event |
| rec_inc | input | 1 | Receive error event |
| rec_inc_amt | input | 4 | Amount added by a receive error event |
| rec_dec | input | 1 | Receive success event |
| recover | input | 1 | Bus-off recovery request |
| ovf_evt | input | 2 | Per-buffer overflow event |
| ovf_clr | input | 2 | Per-buffer overflow flag clear from firmware |
| tec | output | 9 | Transmit error count |
| rec | output | 8 | Receive error count |
| rx_warn | output | 1 | Receive count at or above warning level |
| tx_warn | output | 1 | Transmit count at or above warning level |
| rx_passive | output | 1 | Receive count above passive level |
| tx_passive | output | 1 | Transmit count above passive level |
| bus_off | output | 1 | Transmit count above bus-off level |
| err_state | output | 2 | 0 active, 1 passive, 2 bus-off |
| rx_ovfl | output | 2 | Sticky per-buffer overflow flags |
| err_irq | output | 1 | One-cycle error-interrupt pulse |

## Verification
Some properties are checked by assertions on every cycle:
- single-step decrement and its floor at zero, and receive saturation;
- agreement of the state code with the passive and bus-off flags;
- freezing of the counters in bus-off, and clearing on a recovery request;
- stickiness of the overflow flags;
- the interrupt that follows each overflow event.

The exact thresholds need the bench's scenarios. These are 96 against 95, 127 against 128, and 255 against 256. The bench scenarios also show that the increment beats the decrement when both arrive. They show that a recovery request outside bus-off leaves the counts untouched. Finally, they show the interrupt pulse on the changes of the warning and passive flags.

// File: rtl/can_errmon_pkg.sv
package can_errmon_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } err_state_e;

  typedef struct packed {
    logic rx_warn;
    logic tx_warn;
    logic rx_pas;
    logic tx_pas;
    logic bus_off;
  } err_flags_t;

endpackage

// File: rtl/can_errmon_rst_sync.sv
module can_errmon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/can_errmon_cnt.sv
module can_errmon_cnt #(
  parameter int W       = 8,
  parameter int INC_W   = 4,
  parameter int SAT_MAX = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             zero,
  input  logic             inc,
  input  logic [INC_W-1:0] amt,
  input  logic             dec,
  output logic [W-1:0]     cnt
);

  localparam logic [W:0] SAT_V = (W+1)'(SAT_MAX);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W:0]   sum;
  logic         en;

  // next-state: clear beats hold, increment beats decrement
  always_comb begin
    sum   = {1'b0, cnt_q} + (W+1)'(amt);
    en    = zero | (!hold & (inc | dec));
    cnt_d = cnt_q;
    if (zero) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = (sum > SAT_V) ? SAT_V[W-1:0] : sum[W-1:0];
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/can_errmon_status.sv
module can_errmon_status
  import can_errmon_pkg::*;
#(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 127,
  parameter int BOFF_LIM = 255
) (
  input  logic [TEC_W-1:0] tec,
  input  logic [REC_W-1:0] rec,
  output err_flags_t       flags,
  output err_state_e       state
);

  localparam logic [TEC_W-1:0] T_WARN = TEC_W'(WARN_LIM);
  localparam logic [TEC_W-1:0] T_PASS = TEC_W'(PASS_LIM);
  localparam logic [TEC_W-1:0] T_BOFF = TEC_W'(BOFF_LIM);
  localparam logic [REC_W-1:0] R_WARN = REC_W'(WARN_LIM);
  localparam logic [REC_W-1:0] R_PASS = REC_W'(PASS_LIM);

  always_comb begin
    flags.tx_warn = (tec >= T_WARN);
    flags.tx_pas  = (tec >  T_PASS);
    flags.bus_off = (tec >  T_BOFF);
    flags.rx_warn = (rec >= R_WARN);
    flags.rx_pas  = (rec >  R_PASS);
    if (flags.bus_off)                   state = ST_BUSOFF;
    else if (flags.tx_pas | flags.rx_pas) state = ST_PASSIVE;
    else                                 state = ST_ACTIVE;
  end

endmodule

// File: rtl/can_errmon_ovf.sv
module can_errmon_ovf #(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] evt,
  input  logic [NBUF-1:0] clr,
  output logic [NBUF-1:0] flags,
  output logic            evt_seen
);

  logic [NBUF-1:0] flag_q;
  logic            evt_q;

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_en = evt[gi] | clr[gi];
      flag_d  = evt[gi];           // set has priority over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[gi] <= 1'b0;
      else if (flag_en) flag_q[gi] <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= |evt;
  end

  assign flags    = flag_q;
  assign evt_seen = evt_q;

endmodule

// File: rtl/can_errmon.sv
module can_errmon
  import can_errmon_pkg::*;
#(
  parameter int NUM_RXBUF = 2,
  parameter int INC_W     = 4,
  parameter int TEC_W     = 9,
  parameter int REC_W     = 8,
  parameter int WARN_LIM  = 96,
  parameter int PASS_LIM  = 127,
  parameter int BOFF_LIM  = 255
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tec_inc,
  input  logic [INC_W-1:0]     tec_inc_amt,
  input  logic                 tec_dec,
  input  logic                 rec_inc,
  input  logic [INC_W-1:0]     rec_inc_amt,
  input  logic                 rec_dec,
  input  logic                 recover,
  input  logic [NUM_RXBUF-1:0] ovf_evt,
  input  logic [NUM_RXBUF-1:0] ovf_clr,
  output logic [TEC_W-1:0]     tec,
  output logic [REC_W-1:0]     rec,
  output logic                 rx_warn,
  output logic                 tx_warn,
  output logic                 rx_passive,
  output logic                 tx_passive,
  output logic                 bus_off,
  output logic [1:0]           err_state,
  output logic [NUM_RXBUF-1:0] rx_ovfl,
  output logic                 err_irq
);

  localparam int TEC_MAX = (1 << TEC_W) - 1;
  localparam int REC_MAX = (1 << REC_W) - 1;

  logic       rst_sync_n;
  logic       freeze;
  logic       do_recover;
  logic       ovf_seen;
  err_flags_t flags;
  err_flags_t flags_prev_q;
  err_state_e state;

  can_errmon_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign freeze     = flags.bus_off;
  assign do_recover = recover & flags.bus_off;

  can_errmon_cnt #(.W(TEC_W), .INC_W(INC_W), .SAT_MAX(TEC_MAX)) u_tec (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hold  (freeze),
    .zero  (do_recover),
    .inc   (tec_inc),
    .amt   (tec_inc_amt),
    .dec   (tec_dec),
    .cnt   (tec)
  );

  can_errmon_cnt #(.W(REC_W), .INC_W(INC_W), .SAT_MAX(REC_MAX)) u_rec (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hold  (freeze),
    .zero  (do_recover),
    .inc   (rec_inc),
    .amt   (rec_inc_amt),
    .dec   (rec_dec),
    .cnt   (rec)
  );

  can_errmon_status #(
    .TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM),
    .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)
  ) u_status (
    .tec   (tec),
    .rec   (rec),
    .flags (flags),
    .state (state)
  );

  can_errmon_ovf #(.NBUF(NUM_RXBUF)) u_ovf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (ovf_evt),
    .clr      (ovf_clr),
    .flags    (rx_ovfl),
    .evt_seen (ovf_seen)
  );

  // previous flag snapshot for change detection
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flags_prev_q <= '0;
    else             flags_prev_q <= flags;
  end

  assign err_irq    = (flags != flags_prev_q) | ovf_seen;
  assign rx_warn    = flags.rx_warn;
  assign tx_warn    = flags.tx_warn;
  assign rx_passive = flags.rx_pas;
  assign tx_passive = flags.tx_pas;
  assign bus_off    = flags.bus_off;
  assign err_state  = state;

endmodule

// File: rtl/can_errmon_chk.sv
module can_errmon_chk #(
  parameter int NUM_RXBUF = 2,
  parameter int TEC_W     = 9,
  parameter int REC_W     = 8
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 tec_inc,
  input logic                 tec_dec,
  input logic                 rec_inc,
  input logic                 recover,
  input logic [NUM_RXBUF-1:0] ovf_evt,
  input logic [NUM_RXBUF-1:0] ovf_clr,
  input logic [TEC_W-1:0]     tec,
  input logic [REC_W-1:0]     rec,
  input logic                 tx_warn,
  input logic                 rx_passive,
  input logic                 tx_passive,
  input logic                 bus_off,
  input logic [1:0]           err_state,
  input logic [NUM_RXBUF-1:0] rx_ovfl,
  input logic                 err_irq
);

  localparam logic [REC_W-1:0] REC_TOP = '1;

  p_tec_step_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_off && !tec_inc && tec_dec && tec != '0) |=> (tec == $past(tec) - 1'b1));

  p_tec_floor_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tec_inc && tec == '0) |=> (tec == '0));

  p_rec_sat_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_off && rec_inc && rec == REC_TOP) |=> (rec == REC_TOP));

  p_passive_code_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((rx_passive || tx_passive) && !bus_off) |-> (err_state == 2'd1));

  p_busoff_code_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_off |-> (err_state == 2'd2 && tx_passive && tx_warn));

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_off && !recover) |=> ($stable(tec) && $stable(rec)));

  p_recover_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_off && recover) |=> (tec == '0 && rec == '0 && err_state == 2'd0));

  for (genvar gi = 0; gi < NUM_RXBUF; gi++) begin : g_chk
    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ovf_evt[gi] |=> rx_ovfl[gi]);
    p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rx_ovfl[gi] && !ovf_clr[gi]) |=> rx_ovfl[gi]);
  end

  p_irq_ovf_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ovf_evt) |=> err_irq);

endmodule

bind can_errmon can_errmon_chk #(
  .NUM_RXBUF(NUM_RXBUF), .TEC_W(TEC_W), .REC_W(REC_W)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tec_inc    (tec_inc),
  .tec_dec    (tec_dec),
  .rec_inc    (rec_inc),
  .recover    (recover),
  .ovf_evt    (ovf_evt),
  .ovf_clr    (ovf_clr),
  .tec        (tec),
  .rec        (rec),
  .tx_warn    (tx_warn),
  .rx_passive (rx_passive),
  .tx_passive (tx_passive),
  .bus_off    (bus_off),
  .err_state  (err_state),
  .rx_ovfl    (rx_ovfl),
  .err_irq    (err_irq)
);

// File: tb/can_errmon_tb_top.sv
module can_errmon_tb_top;

  localparam int CLK_P = 10;
  localparam int NVEC  = 20;

  typedef struct packed {
    logic       ti;
    logic [3:0] ta;
    logic       td;
    logic       ri;
    logic [3:0] ra;
    logic       rd;
    logic       rcv;
    logic [1:0] evt;
    logic [1:0] clr;
    logic [8:0] et;
    logic [7:0] er;
    logic [1:0] eo;
    logic       ei;
  } vec_t;

  // ti ta td ri ra rd rcv evt clr | exp tec rec ovfl irq
  localparam vec_t VEC [NVEC] = '{
    {1'b1,4'd15,1'b0, 1'b1,4'd15,1'b0, 1'b0,2'b00,2'b00, 9'd15, 8'd15, 2'b00,1'b0},
    {1'b1,4'd15,1'b0, 1'b1,4'd15,1'b0, 1'b0,2'b00,2'b00, 9'd30, 8'd30, 2'b00,1'b0},
    {1'b1,4'd15,1'b0, 1'b1,4'd15,1'b0, 1'b0,2'b00,2'b00, 9'd45, 8'd45, 2'b00,1'b0},
    {1'b1,4'd15,1'b0, 1'b1,4'd15,1'b0, 1'b0,2'b00,2'b00, 9'd60, 8'd60, 2'b00,1'b0},
    {1'b1,4'd15,1'b0, 1'b1,4'd15,1'b0, 1'b0,2'b00,2'b00, 9'd75, 8'd75, 2'b00,1'b0},
    {1'b1,4'd15,1'b0, 1'b1,4'd15,1'b0, 1'b0,2'b00,2'b00, 9'd90, 8'd90, 2'b00,1'b0},
    {1'b1,4'd5, 1'b0, 1'b1,4'd6, 1'b0, 1'b0,2'b00,2'b00, 9'd95, 8'd96, 2'b00,1'b1},
    {1'b1,4'd1, 1'b0, 1'b0,4'd0, 1'b1, 1'b0,2'b00,2'b00, 9'd96, 8'd95, 2'b00,1'b1},
    {1'b1,4'd1, 1'b1, 1'b1,4'd1, 1'b1, 1'b0,2'b00,2'b00, 9'd97, 8'd96, 2'b00,1'b1},
    {1'b0,4'd0, 1'b0, 1'b0,4'd0, 1'b0, 1'b0,2'b01,2'b00, 9'd97, 8'd96, 2'b01,1'b1},
    {1'b0,4'd0, 1'b0, 1'b0,4'd0, 1'b0, 1'b0,2'b10,2'b01, 9'd97, 8'd96, 2'b10,1'b1},
    {1'b0,4'd0, 1'b0, 1'b0,4'd0, 1'b0, 1'b0,2'b01,2'b01, 9'd97, 8'd96, 2'b11,1'b1},
    {1'b0,4'd0, 1'b0, 1'b0,4'd0, 1'b0, 1'b0,2'b00,2'b11, 9'd97, 8'd96, 2'b00,1'b0},
    {1'b0,4'd0, 1'b1, 1'b0,4'd0, 1'b0, 1'b0,2'b00,2'b00, 9'd96, 8'd96, 2'b00,1'b0},
    {1'b0,4'd0, 1'b0, 1'b0,4'd0, 1'b0, 1'b1,2'b00,2'b00, 9'd96, 8'd96, 2'b00,1'b0},
    {1'b1,4'd15,1'b0, 1'b0,4'd0, 1'b0, 1'b0,2'b00,2'b00, 9'd111,8'd96, 2'b00,1'b0},
    {1'b1,4'd15,1'b0, 1'b0,4'd0, 1'b0, 1'b0,2'b00,2'b00, 9'd126,8'd96, 2'b00,1'b0},
    {1'b1,4'd1, 1'b0, 1'b0,4'd0, 1'b0, 1'b0,2'b00,2'b00, 9'd127,8'd96, 2'b00,1'b0},
    {1'b1,4'd1, 1'b0, 1'b0,4'd0, 1'b0, 1'b0,2'b00,2'b00, 9'd128,8'd96, 2'b00,1'b1},
    {1'b0,4'd0, 1'b1, 1'b0,4'd0, 1'b0, 1'b0,2'b00,2'b00, 9'd127,8'd96, 2'b00,1'b1}
  };

  logic       clk;
  logic       rst_n;
  logic       tec_inc, tec_dec, rec_inc, rec_dec, recover;
  logic [3:0] tec_inc_amt, rec_inc_amt;
  logic [1:0] ovf_evt, ovf_clr;
  logic [8:0] tec;
  logic [7:0] rec;
  logic       rx_warn, tx_warn, rx_passive, tx_passive, bus_off, err_irq;
  logic [1:0] err_state;
  logic [1:0] rx_ovfl;

  int n_chk;
  int n_fail;
  bit done;

  can_errmon dut_i (
    .clk(clk), .rst_n(rst_n),
    .tec_inc(tec_inc), .tec_inc_amt(tec_inc_amt), .tec_dec(tec_dec),
    .rec_inc(rec_inc), .rec_inc_amt(rec_inc_amt), .rec_dec(rec_dec),
    .recover(recover), .ovf_evt(ovf_evt), .ovf_clr(ovf_clr),
    .tec(tec), .rec(rec), .rx_warn(rx_warn), .tx_warn(tx_warn),
    .rx_passive(rx_passive), .tx_passive(tx_passive), .bus_off(bus_off),
    .err_state(err_state), .rx_ovfl(rx_ovfl), .err_irq(err_irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge; outputs are read one falling edge later.
  task automatic drive(input logic ti, input logic [3:0] ta, input logic td,
                       input logic ri, input logic [3:0] ra, input logic rd,
                       input logic rcv, input logic [1:0] evt, input logic [1:0] clr);
    tec_inc = ti; tec_inc_amt = ta; tec_dec = td;
    rec_inc = ri; rec_inc_amt = ra; rec_dec = rd;
    recover = rcv; ovf_evt = evt; ovf_clr = clr;
    @(negedge clk);
    tec_inc = 1'b0; tec_inc_amt = '0; tec_dec = 1'b0;
    rec_inc = 1'b0; rec_inc_amt = '0; rec_dec = 1'b0;
    recover = 1'b0; ovf_evt = '0; ovf_clr = '0;
  endtask

  // flag and state expectations from R4, R5, R6
  task automatic check_flags(input string req, input int et, input int er);
    int st;
    st = (et > 255) ? 2 : ((et > 127 || er > 127) ? 1 : 0);
    check(req, "tx_warn",    tx_warn,    int'(et >= 96));
    check(req, "rx_warn",    rx_warn,    int'(er >= 96));
    check(req, "tx_passive", tx_passive, int'(et > 127));
    check(req, "rx_passive", rx_passive, int'(er > 127));
    check(req, "bus_off",    bus_off,    int'(et > 255));
    check(req, "err_state",  err_state,  st);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    tec_inc = 1'b0; tec_inc_amt = '0; tec_dec = 1'b0;
    rec_inc = 1'b0; rec_inc_amt = '0; rec_dec = 1'b0;
    recover = 1'b0; ovf_evt = '0; ovf_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1", "tec", tec, 0);
    check("R1", "rec", rec, 0);
    check("R1", "rx_ovfl", rx_ovfl, 0);
    check("R1", "err_irq", err_irq, 0);
    check_flags("R1", 0, 0);

    // Table: R2 R3 R4 R5 R9 R10, and R8 (recover outside bus-off ignored)
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].ti, VEC[i].ta, VEC[i].td, VEC[i].ri, VEC[i].ra, VEC[i].rd,
            VEC[i].rcv, VEC[i].evt, VEC[i].clr);
      check("R2", "tec", tec, VEC[i].et);
      check("R3", "rec", rec, VEC[i].er);
      check("R9", "rx_ovfl", rx_ovfl, VEC[i].eo);
      check("R10", "err_irq", err_irq, VEC[i].ei);
      check_flags("R5", VEC[i].et, VEC[i].er);
    end

    // R3 receive saturation: 96 + 11*15 clips to 255
    for (int k = 0; k < 11; k++) drive(0, 0, 0, 1, 4'd15, 0, 0, 0, 0);
    check("R3", "rec saturated", rec, 255);
    check_flags("R5", 127, 255);
    drive(0, 0, 0, 1, 4'd15, 0, 0, 0, 0);
    check("R3", "rec stays saturated", rec, 255);

    // R6 boundary: 255 is not bus-off, 256 is
    for (int k = 0; k < 128; k++) drive(1, 4'd1, 0, 0, 0, 0, 0, 0, 0);
    check("R6", "tec at 255", tec, 255);
    check_flags("R6", 255, 255);
    drive(1, 4'd1, 0, 0, 0, 0, 0, 0, 0);
    check("R6", "tec at 256", tec, 256);
    check_flags("R6", 256, 255);
    check("R10", "irq on bus-off entry", err_irq, 1);

    // R7 events ignored in bus-off
    drive(1, 4'd15, 1, 1, 4'd1, 1, 0, 0, 0);
    check("R7", "tec frozen", tec, 256);
    check("R7", "rec frozen", rec, 255);
    check("R7", "err_irq", err_irq, 0);
    drive(0, 0, 1, 0, 0, 1, 0, 0, 0);
    check("R7", "tec frozen on dec", tec, 256);

    // R8 recovery
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
    check("R8", "tec cleared", tec, 0);
    check("R8", "rec cleared", rec, 0);
    check_flags("R8", 0, 0);
    check("R10", "irq on recovery", err_irq, 1);

    // R2 R3 floor at zero
    drive(0, 0, 1, 0, 0, 1, 0, 0, 0);
    check("R2", "tec floor", tec, 0);
    check("R3", "rec floor", rec, 0);
    check("R10", "no irq when idle", err_irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule